// File: doc/BRIEF.md
# Flyback Stroke Controller

This block decides, clock by clock, when the power switch of a quasi-resonant flyback converter conducts. A stroke has three phases. In the primary phase the gate is high until the current comparator trips. In the secondary phase the gate is low while the transformer delivers its energy. In the waiting phase the block waits for the oscillator period to expire and for the drain ringing to reach a valley. The analog comparators for current sense, auxiliary-winding demagnetization, drain valley, open auxiliary input and output over-voltage all arrive as single-bit flags. The oscillator period comes as a cycle count from an external frequency-reduction loop.

Five protection mechanisms are built in:
- The current comparator is blanked just after turn-on.
- Demagnetization detection is suppressed just after turn-off.
- A watchdog limits the on-time and raises a restart-request fault when the limit is exceeded.
- An open auxiliary input holds the switch off for as long as it lasts.
- An asymmetric up/down counter filters the per-stroke over-voltage flag and latches a fault once the flag has dominated for long enough.

A peak-limit select output tells the current-limit circuit to use a quarter of the full level while frequency reduction is active. All timing values are parameters counted in clock cycles. The defaults assume a 10 MHz clock: 8 µs minimum period, 2 µs demagnetization suppression, 3-cycle blanking and 25 µs maximum on-time.

Top module: `flyback_stroke_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it is released, `gate`, `ovp_fault`, `ton_fault` and `pk_quarter` are all 0.
- R2: The gate rises only at a clock edge where `valley` was 1. While `valley` is held at 0 the gate stays low. If the other start conditions are already met, raising `valley` makes the gate high one cycle later.
- R3: Two consecutive gate rising edges are at least max(`period_in`, MIN_PERIOD) cycles apart. When the stroke itself is shorter than that, the spacing is exactly that many cycles.
- R4: `demag_done` is ignored during the first DEMAG_SUP cycles after the gate falls. A stroke whose demagnetization flag arrives d cycles after the fall is followed by the next rise no earlier than w + 2 + max(d, DEMAG_SUP) cycles after the previous rise, where w is the on-time in cycles.
- R5: `sense_trip` is ignored during the first BLANK cycles of the on-time. When the trip is first seen in on-cycle s, with s counted from 0, the gate is high for max(s, BLANK) + 1 cycles.
- R6: The gate rises at most once per stroke. After it falls it stays low until a new demagnetization end has been accepted.
- R7: If the gate has been high for TON_MAX cycles without a valid trip, it falls and `ton_fault` is set. `ton_fault` stays set until reset. A trip seen in the last allowed cycle ends the pulse without a fault.
- R8: `pk_quarter` takes the value of `freq_red` one cycle later while the gate is low. It holds its value while the gate is high.
- R9: `aux_open` forces a high gate low at the next clock edge and blocks every turn-on while it is 1. Strokes resume once it returns to 0.
- R10: `ovp_flag` is sampled once per stroke, at the edge where demagnetization end is accepted. The over-voltage count goes up by 1 on a flagged stroke. On an unflagged stroke it goes down by 2, but never below 0.
- R11: When the count reaches OVP_LIMIT (default 8), `ovp_fault` is set and no further stroke starts. Only `latch_clr` or reset clears the fault and the count, after which strokes resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_in | input | PW | Oscillator period in cycles from the frequency-reduction loop |
| freq_red | input | 1 | Frequency-reduction mode active |
| sense_trip | input | 1 | Current sense has reached the limit |
| demag_done | input | 1 | Auxiliary winding reports the end of the secondary stroke |
| valley | input | 1 | Drain voltage is at a valley |
| aux_open | input | 1 | Auxiliary input is open-circuit |
| ovp_flag | input | 1 | Output over-voltage seen in this stroke |
| latch_clr | input | 1 | Clears the latched over-voltage fault and its count |
| gate | output | 1 | Power switch drive |
| pk_quarter | output | 1 | 1 selects a quarter peak limit, 0 selects the full limit |
| ovp_fault | output | 1 | Latched over-voltage fault |
| ton_fault | output | 1 | Maximum on-time fault, a restart request |

## Verification
Every output changes exactly one cycle after the input edge that causes it. The gate rises one cycle after the edge at which the start conditions hold. It falls one cycle after the trip, timeout or open-auxiliary edge. `pk_quarter` follows `freq_red` one cycle later. `ovp_fault` is set at the edge that accepts the end of demagnetization for the offending stroke.

The bench drives the comparator flags from its own model of the stroke, counted in negative-edge samples from each gate edge. This reproduces the block's latencies: on-time is max(s, BLANK) + 1, and rise spacing is max(target, w + 2 + max(d, DEMAG_SUP)). The bench reads every result half a cycle after the clock edge that produces it. It sweeps trip position, demagnetization delay and period. It also replays over-voltage patterns and compares the stroke index at which the fault appears against an arithmetic model of the counter.

// File: rtl/fbc_pkg.sv
// Shared types for the flyback stroke controller.
package fbc_pkg;

    // Phase of the current switching stroke.
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // waiting for period, valley and permission
        ST_ON   = 2'd1,   // primary stroke, gate high
        ST_SEC  = 2'd2    // secondary stroke, waiting for demagnetization
    } stroke_e;

endpackage

// File: rtl/fbc_stroke_seq.sv
// Stroke sequencer: runs the wait / on / secondary phases of each stroke.
// It applies leading-edge blanking, demagnetization suppression, the
// on-time watchdog and the oscillator-period limit, and pulses demag_end
// once per stroke when the end of the secondary stroke is accepted.
// Assumes the input flags are already synchronous to clk.
module fbc_stroke_seq
    import fbc_pkg::*;
#(
    parameter int PW         = 12,
    parameter int MIN_PERIOD = 80,
    parameter int DEMAG_SUP  = 20,
    parameter int BLANK      = 3,
    parameter int TON_MAX    = 250
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_in,
    input  logic          sense_trip,
    input  logic          demag_done,
    input  logic          valley,
    input  logic          inhibit,
    output logic          gate,
    output logic          demag_end,
    output logic          ton_fault
);
    localparam int OW = $clog2(TON_MAX + 1);
    localparam int SW = $clog2(DEMAG_SUP + 1);
    localparam logic [PW-1:0] MIN_P    = PW'(MIN_PERIOD);
    localparam logic [OW-1:0] BLANK_C  = OW'(BLANK);
    localparam logic [OW-1:0] TON_LAST = OW'(TON_MAX - 1);
    localparam logic [SW-1:0] SUP_C    = SW'(DEMAG_SUP);
    localparam logic [OW:0]   TON_CAP  = (OW + 1)'(TON_MAX);

    stroke_e       state;
    logic [PW-1:0] per_cnt;
    logic [PW-1:0] target;
    logic [OW-1:0] on_cnt;
    logic [SW-1:0] sup_cnt;
    logic          start;
    logic          trip_ok;
    logic          sup_done;

    // Combine the period, blanking, suppression and start conditions.
    always_comb begin
        target    = (period_in > MIN_P) ? period_in : MIN_P;
        sup_done  = (sup_cnt == SUP_C);
        trip_ok   = sense_trip && (on_cnt >= BLANK_C);
        start     = (state == ST_WAIT) && valley && !inhibit && !ton_fault
                    && (per_cnt >= target - 1'b1);
        gate      = (state == ST_ON);
        demag_end = (state == ST_SEC) && demag_done && sup_done;
    end

    // Count the cycles since the last turn-on, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_cnt <= '1;
        else if (start)
            per_cnt <= '0;
        else if (per_cnt != '1)
            per_cnt <= per_cnt + 1'b1;
    end

    // Step the stroke phases and latch the on-time fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_WAIT;
            on_cnt    <= '0;
            sup_cnt   <= '0;
            ton_fault <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (start) begin
                        state  <= ST_ON;
                        on_cnt <= '0;
                    end
                end
                ST_ON: begin
                    on_cnt <= on_cnt + 1'b1;
                    if (trip_ok || inhibit) begin
                        state   <= ST_SEC;
                        sup_cnt <= '0;
                    end else if (on_cnt == TON_LAST) begin
                        state     <= ST_SEC;
                        sup_cnt   <= '0;
                        ton_fault <= 1'b1;
                    end
                end
                ST_SEC: begin
                    if (!sup_done)
                        sup_cnt <= sup_cnt + 1'b1;
                    if (demag_done && sup_done)
                        state <= ST_WAIT;
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    // Checker state: cycles since the last rise and length of the current high run.
    logic [PW-1:0] since_rise;
    logic [OW:0]   hi_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rise <= '1;
            hi_run     <= '0;
        end else begin
            since_rise <= (gate && hi_run == '0) ? PW'(1) :
                          (since_rise != '1) ? since_rise + 1'b1 : since_rise;
            hi_run     <= gate ? hi_run + 1'b1 : '0;
        end
    end

    a_r2_rise_needs_valley: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(valley));
    a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(since_rise) >= MIN_P - 1'b1));
    a_r7_on_time_bound: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= TON_CAP);
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ton_fault |=> ton_fault);
endmodule

// File: rtl/fbc_ovp_filter.sv
// Over-voltage event filter: an up/down counter sampled once per stroke.
// It goes up by one on a flagged stroke and down by two, floored at zero,
// on a clean one. It latches a fault when the count reaches LIMIT.
// Assumes sample pulses for one cycle per stroke.
module fbc_ovp_filter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic ovp_flag,
    input  logic clear,
    output logic fault
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] TWO  = CW'(2);
    localparam logic [CW-1:0] CAP  = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Update the count once per stroke and latch the fault at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt   <= '0;
            fault <= 1'b0;
        end else if (sample && !fault) begin
            if (ovp_flag) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST)
                    fault <= 1'b1;
            end else begin
                cnt <= (cnt >= TWO) ? cnt - TWO : '0;
            end
        end
    end

    a_r11_count_below_cap: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (cnt < CAP));
    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clear) |=> fault);
    a_r10_down_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !ovp_flag && !fault && !clear) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/flyback_stroke_ctrl.sv
// Flyback stroke controller top. It joins the stroke sequencer and the
// over-voltage filter, blocks switching while the auxiliary input is open
// or a fault is latched, and selects the quarter peak limit in
// frequency-reduction mode. Assumes all inputs are synchronous to clk.
module flyback_stroke_ctrl #(
    parameter int PW         = 12,
    parameter int MIN_PERIOD = 80,
    parameter int DEMAG_SUP  = 20,
    parameter int BLANK      = 3,
    parameter int TON_MAX    = 250,
    parameter int OVP_LIMIT  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_in,
    input  logic          freq_red,
    input  logic          sense_trip,
    input  logic          demag_done,
    input  logic          valley,
    input  logic          aux_open,
    input  logic          ovp_flag,
    input  logic          latch_clr,
    output logic          gate,
    output logic          pk_quarter,
    output logic          ovp_fault,
    output logic          ton_fault
);
    logic demag_end;
    logic inhibit;

    // Conditions that stop switching at once.
    assign inhibit = aux_open || ovp_fault;

    fbc_stroke_seq #(
        .PW(PW), .MIN_PERIOD(MIN_PERIOD), .DEMAG_SUP(DEMAG_SUP),
        .BLANK(BLANK), .TON_MAX(TON_MAX)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .period_in(period_in),
        .sense_trip(sense_trip), .demag_done(demag_done), .valley(valley),
        .inhibit(inhibit), .gate(gate), .demag_end(demag_end),
        .ton_fault(ton_fault)
    );

    fbc_ovp_filter #(.LIMIT(OVP_LIMIT)) u_ovp (
        .clk(clk), .rst_n(rst_n), .sample(demag_end), .ovp_flag(ovp_flag),
        .clear(latch_clr), .fault(ovp_fault)
    );

    // Load the peak-limit select only while the switch is off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pk_quarter <= 1'b0;
        else if (!gate)
            pk_quarter <= freq_red;
    end

    a_r9_no_rise_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> !$past(aux_open));
    a_r11_gate_low_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_fault || ton_fault) |-> !gate);
    a_r8_limit_held_on: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && $past(gate)) |-> $stable(pk_quarter));
endmodule

// File: tb/test_flyback_stroke_ctrl.sv
module test_flyback_stroke_ctrl;
    localparam int PW = 8, MINP = 12, SUP = 4, BLK = 2, TMAX = 10, LIM = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [PW-1:0] period_in = '0;
    logic freq_red = 1'b0, sense_trip = 1'b0, demag_done = 1'b0, valley = 1'b0;
    logic aux_open = 1'b0, ovp_flag = 1'b0, latch_clr = 1'b0;
    logic gate, pk_quarter, ovp_fault, ton_fault;

    flyback_stroke_ctrl #(.PW(PW), .MIN_PERIOD(MINP), .DEMAG_SUP(SUP),
        .BLANK(BLK), .TON_MAX(TMAX), .OVP_LIMIT(LIM)) i_flyback_stroke_ctrl (
        .clk(clk), .rst_n(rst_n), .period_in(period_in), .freq_red(freq_red),
        .sense_trip(sense_trip), .demag_done(demag_done), .valley(valley),
        .aux_open(aux_open), .ovp_flag(ovp_flag), .latch_clr(latch_clr),
        .gate(gate), .pk_quarter(pk_quarter), .ovp_fault(ovp_fault),
        .ton_fault(ton_fault));

    always #10 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    // environment model state
    int t = 0, rises = 0, last_rise = 0, spacing = 0, on_tb = 0, off_tb = 0, last_w = 0;
    int sw = 0, dly = 0, ovp_base = 0;
    bit prev_gate = 1'b0, ovp_en = 1'b0;
    logic [31:0] ovp_pat = '0;

    // Plant model: drive comparator flags from the gate history.
    always @(negedge clk) begin
        if (gate === 1'b1 && !prev_gate) begin
            rises++; spacing = t - last_rise; last_rise = t; on_tb = 0;
        end else if (gate === 1'b1) on_tb++;
        if (gate === 1'b0 && prev_gate) begin
            last_w = on_tb + 1; off_tb = 0;
        end else if (gate === 1'b0 && off_tb < 1000) off_tb++;
        prev_gate = (gate === 1'b1);
        sense_trip = prev_gate && (on_tb >= sw);
        demag_done = !prev_gate && (off_tb >= dly);
        ovp_flag = ovp_en && (rises > ovp_base) && ovp_pat[(rises - ovp_base - 1) % 32];
        t++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #2;
    endtask

    task automatic quiesce();
        valley = 1'b0;
        repeat (40) step();
    endtask

    task automatic wait_rises(input int n);
        int r0 = rises, g = 0;
        while (rises < r0 + n && g < 3000) begin step(); g++; end
        check(g < 3000, "stroke timeout", rises - r0, n);
    endtask

    task automatic wait_low();
        int g = 0;
        while (gate && g < 100) begin step(); g++; end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Stroke index at which the count reaches the limit, 0 if never within 32.
    function automatic int ovp_model(input logic [31:0] p);
        int c = 0;
        for (int n = 0; n < 32; n++) begin
            if (p[n]) begin
                c++;
                if (c == LIM) return n + 1;
            end else c = (c >= 2) ? c - 2 : 0;
        end
        return 0;
    endfunction

    initial begin
        int r0, exp_w, exp_s, tgt, got;
        logic [31:0] pats [6];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h5555_5555; pats[2] = 32'h7777_7777;
        pats[3] = 32'hFFFF_FF7F; pats[4] = 32'h0000_0000; pats[5] = 32'hFFFF_FF00;

        repeat (3) step();
        // R1 reset state
        check(gate == 0, "R1 gate in reset", gate, 0);
        check(ovp_fault == 0 && ton_fault == 0, "R1 faults in reset", ovp_fault + ton_fault, 0);
        check(pk_quarter == 0, "R1 pk in reset", pk_quarter, 0);
        rst_n = 1'b1;
        step();
        check(gate == 0 && pk_quarter == 0, "R1 after release", gate, 0);

        // R3 R4 R5 R6 sweep: trip position, demag delay, period
        for (int pi = 0; pi < 3; pi++) begin
            for (int s = 0; s < 7; s++) begin
                for (int d = 0; d < 8; d++) begin
                    quiesce();
                    period_in = (pi == 0) ? 8'd0 : (pi == 1) ? 8'd13 : 8'd22;
                    tgt = imax(int'(period_in), MINP);
                    sw = s; dly = d;
                    valley = 1'b1;
                    wait_rises(3);
                    wait_low();
                    exp_w = imax(s, BLK) + 1;
                    exp_s = imax(tgt, exp_w + 2 + imax(d, SUP));
                    check(last_w == exp_w, "R5 on-time", last_w, exp_w);
                    check(spacing == exp_s, "R3 R4 R6 rise spacing", spacing, exp_s);
                end
            end
        end
        sw = 0; dly = 0; period_in = '0;

        // R2 valley gating
        quiesce();
        r0 = rises;
        repeat (60) step();
        check(rises == r0 && gate == 0, "R2 no start without valley", rises - r0, 0);
        valley = 1'b1;
        step();
        check(gate == 1, "R2 start one cycle after valley", gate, 1);

        // R9 open auxiliary input
        quiesce();
        sw = 8; valley = 1'b1;
        begin int g = 0; while (!gate && g < 100) begin step(); g++; end end
        aux_open = 1'b1;
        step();
        check(gate == 0, "R9 gate cut next cycle", gate, 0);
        check(last_w == 1, "R9 pulse width", last_w, 1);
        r0 = rises;
        repeat (60) step();
        check(rises == r0, "R9 no start while open", rises - r0, 0);
        aux_open = 1'b0;
        repeat (20) step();
        check(rises > r0, "R9 resume after clear", rises - r0, 1);

        // R8 peak-limit select
        quiesce();
        freq_red = 1'b1;
        step();
        check(pk_quarter == 1, "R8 follows while low", pk_quarter, 1);
        sw = 8; valley = 1'b1;
        begin int g = 0; while (!gate && g < 100) begin step(); g++; end end
        freq_red = 1'b0;
        step();
        check(gate == 1 && pk_quarter == 1, "R8 held while high", pk_quarter, 1);
        wait_low();
        step();
        check(pk_quarter == 0, "R8 updates after fall", pk_quarter, 0);

        // R7 on-time watchdog
        quiesce();
        sw = TMAX - 1; valley = 1'b1;
        wait_rises(2); wait_low();
        check(last_w == TMAX, "R7 trip in last cycle width", last_w, TMAX);
        check(ton_fault == 0, "R7 no fault on last-cycle trip", ton_fault, 0);
        quiesce();
        sw = TMAX + 5; valley = 1'b1;
        wait_rises(1); wait_low();
        check(last_w == TMAX, "R7 timeout width", last_w, TMAX);
        check(ton_fault == 1, "R7 fault set", ton_fault, 1);
        r0 = rises;
        repeat (60) step();
        check(rises == r0 && ton_fault == 1, "R7 fault holds and blocks", rises - r0, 0);
        rst_n = 1'b0; valley = 1'b0; sw = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(ton_fault == 0, "R7 R1 reset clears fault", ton_fault, 0);

        // R10 R11 over-voltage pattern replay
        for (int k = 0; k < 6; k++) begin
            quiesce();
            latch_clr = 1'b1; step(); latch_clr = 1'b0;
            ovp_base = rises; ovp_pat = pats[k]; ovp_en = 1'b1;
            valley = 1'b1;
            begin int g = 0;
                while (!ovp_fault && rises - ovp_base < 33 && g < 1500) begin step(); g++; end
            end
            got = ovp_fault ? rises - ovp_base : 0;
            check(got == ovp_model(pats[k]), "R10 R11 fault stroke index", got, ovp_model(pats[k]));
            ovp_en = 1'b0;
            if (ovp_fault) begin
                r0 = rises;
                repeat (40) step();
                check(rises == r0 && gate == 0 && ovp_fault == 1, "R11 latched blocks", rises - r0, 0);
                latch_clr = 1'b1; step(); latch_clr = 1'b0;
                check(ovp_fault == 0, "R11 clear input", ovp_fault, 0);
                repeat (30) step();
                check(rises > r0, "R11 resume after clear", rises - r0, 1);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule